// File: doc/BRIEF.md
# MDIO Register Command Engine

This block is a management-bus controller for external Ethernet PHYs. Software writes one 32-bit command word that names the PHY, the PHY register, the write data, and whether the access is a read or a write. The engine then sends a complete Clause-22 management frame on the MDC clock and the bidirectional MDIO data pin. On a read, it captures the PHY's sixteen data bits.

Completion is shown in a 32-bit status word. The status word carries one flag for a finished write and one flag for finished read data, and it returns the captured read data in its upper half. Driver software waits for a flag to be clear, issues a command, and then polls the flag until it is set. Reading the status word with the read strobe clears both flags, so every transaction leaves the flags in a known state for the next one.

MDC is produced inside the block by dividing the system clock. The half period is set at build time from the system clock frequency and the highest MDC frequency allowed, which is 2.5 MHz by default.

Top module: `mdio_cmd_engine`

## Requirements
- R1: In the command word, bits [4:0] give the PHY address, bits [12:8] give the register number and bits [31:16] give the write data. Bit 14 requests a read and bit 13 requests a write. When both bits are set, the command is a read.
- R2: Each transaction sends 64 bits, most significant bit first, in this order: 32 ones, the start pattern 01, the opcode (10 for a read, 01 for a write), 5 PHY address bits, 5 register bits, 2 turnaround bits and 16 data bits.
- R3: MDC has a period of 2*HALF system clocks, where HALF = ceil(CLK_HZ / (2*MDC_HZ)). MDC is low whenever no transaction is in progress.
- R4: During a write, the engine drives MDIO for all 64 bits and sends 10 in the turnaround bits. When the frame ends, status bit 0 (write done) is set.
- R5: During a read, the engine releases MDIO (output enable low) from the first turnaround bit to the end of the frame. It samples the data bits on the rising edge of MDC. When the frame ends, status bit 1 (read ready) is set and status bits [31:16] hold the 16 sampled bits.
- R6: A status read strobe clears both status flags. It leaves the returned data unchanged.
- R7: Accepting a write clears status bit 0, and accepting a read clears status bit 1. The other flag is unchanged.
- R8: A command written while a transaction is in progress is ignored. A command with neither bit 13 nor bit 14 set is also ignored. Neither one starts a frame or changes a flag.
- R9: After reset, the status word reads zero, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| stat_re | input | 1 | Read strobe for the status word; clears both flags |
| stat_rdata | output | 32 | Status word: flags in bits [1:0], read data in bits [31:16] |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the engine with CLK_HZ = 50 MHz and MDC_HZ = 10 MHz. These values give a half period of 3 clocks from a ratio of 2.5, so the round-up in the divider is checked directly. Each frame lasts 384 cycles, which is short enough to run many transactions, including all-ones and all-zeros fields and maximum addresses. This frame length also leaves enough time to issue a second command while the first frame is still running. A PHY model in the bench decodes every frame from the pins, answers reads with data derived from the address, and compares each frame with the queue of expected transactions.

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
  parameter int CLK_HZ = 50_000_000,
  parameter int MDC_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        stat_re,
  output logic [31:0] stat_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF  = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int NBITS = 64;
  localparam int TA_AT = 46;
  localparam int DA_AT = 48;

  logic          active, rd_mode, wr_done, rd_rdy;
  logic [HW-1:0] cnt;
  logic [5:0]    bitn;
  logic [63:0]   sr;
  logic [15:0]   rsh, rdata;

  wire go    = cmd_we && !active && (cmd_wdata[14] || cmd_wdata[13]);
  wire go_rd = cmd_wdata[14];
  wire tick  = active && (cnt == HW'(HALF - 1));
  wire rise  = tick && !mdc;
  wire fall  = tick && mdc;
  wire last  = fall && (bitn == 6'(NBITS - 1));

  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, go_rd ? 2'b10 : 2'b01,
                       cmd_wdata[4:0], cmd_wdata[12:8], 2'b10,
                       go_rd ? 16'h0000 : cmd_wdata[31:16]};

  assign stat_rdata = {rdata, 14'd0, rd_rdy, wr_done};
  assign mdio_o     = active ? sr[63] : 1'b1;
  assign mdio_oe    = active && !(rd_mode && bitn >= 6'(TA_AT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_mode <= 1'b0;
      wr_done <= 1'b0;
      rd_rdy  <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      sr      <= '0;
      rsh     <= '0;
      rdata   <= '0;
      mdc     <= 1'b0;
    end else begin
      if (stat_re) begin
        wr_done <= 1'b0;
        rd_rdy  <= 1'b0;
      end
      if (go) begin
        active  <= 1'b1;
        rd_mode <= go_rd;
        sr      <= frame;
        cnt     <= '0;
        bitn    <= '0;
        mdc     <= 1'b0;
        if (go_rd) rd_rdy  <= 1'b0;
        else       wr_done <= 1'b0;
      end else if (active) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) mdc <= ~mdc;
        if (rise && rd_mode && bitn >= 6'(DA_AT)) rsh <= {rsh[14:0], mdio_i};
        if (fall) begin
          sr   <= {sr[62:0], 1'b1};
          bitn <= bitn + 1'b1;
        end
        if (last) begin
          active <= 1'b0;
          if (rd_mode) begin
            rd_rdy <= 1'b1;
            rdata  <= rsh;
          end else begin
            wr_done <= 1'b1;
          end
        end
      end
    end
  end

  a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdc);
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_mode && bitn >= 6'(TA_AT)) |-> !mdio_oe);
  a_r4_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |-> $past(active) && !$past(rd_mode));
  a_r6_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && !last) |=> stat_rdata[1:0] == 2'b00);
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && cmd_we) |=> $stable(rd_mode) && active);
endmodule

// File: tb/tb_mdio_cmd_engine.sv
module tb_mdio_cmd_engine;
  typedef struct packed {
    logic       rd;
    logic [4:0] pa;
    logic [4:0] ra;
    logic [15:0] d;
  } item_t;

  logic clk = 0, rst_n = 0, cmd_we = 0, stat_re = 0, mdio_i = 1;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] stat_rdata;
  logic mdc, mdio_o, mdio_oe;
  int tests = 0, fails = 0, frames = 0, cyc = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_cmd_engine #(.CLK_HZ(50_000_000), .MDC_HZ(10_000_000)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_re(stat_re), .stat_rdata(stat_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic logic [15:0] phy_val(logic [4:0] pa, logic [4:0] ra);
    return {pa, ra, 6'h15} ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(bit rdb, bit wrb, logic [4:0] pa, logic [4:0] ra,
                     logic [15:0] d, bit expect_frame);
    item_t it;
    @(negedge clk);
    cmd_wdata = {d, 1'b0, rdb, wrb, ra, 3'b000, pa};
    cmd_we = 1;
    if (expect_frame) begin
      it.rd = rdb; it.pa = pa; it.ra = ra;
      it.d = rdb ? phy_val(pa, ra) : d;
      exp_q.push_back(it);
    end
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wait_flag(int b, string tag);
    int n = 0;
    while (!stat_rdata[b] && n < 5000) begin @(negedge clk); n++; end
    chk(stat_rdata[b] == 1'b1, tag, stat_rdata, 1);
  endtask

  task automatic clear_status;
    @(negedge clk); stat_re = 1;
    @(negedge clk); stat_re = 0;
  endtask

  // scoreboard monitor acting as the PHY
  initial begin
    logic [63:0] f, o;
    item_t it;
    int last_rise;
    bit per_ok;
    forever begin
      per_ok = 1;
      for (int i = 0; i < 64; i++) begin
        @(posedge mdc);
        if (i > 0 && cyc - last_rise != 6) per_ok = 0;
        last_rise = cyc;
        f[63-i] = mdio_o;
        o[63-i] = mdio_oe;
        if (i >= 47 && i <= 62 && exp_q.size() > 0 && exp_q[0].rd) begin
          @(negedge mdc);
          mdio_i = exp_q[0].d[62-i];
        end
      end
      @(negedge mdc);
      mdio_i = 1;
      frames++;
      chk(per_ok, "R3 mdc period 6 clocks", 0, 6);
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected frame", f, 0);
      end else begin
        it = exp_q.pop_front();
        chk(f[63:32] == 32'hFFFF_FFFF && f[31:30] == 2'b01, "R2 preamble/start", f[63:30], {32'hFFFF_FFFF, 2'b01});
        chk(f[29:28] == (it.rd ? 2'b10 : 2'b01), "R1 R2 opcode", f[29:28], it.rd ? 2'b10 : 2'b01);
        chk(f[27:23] == it.pa && f[22:18] == it.ra, "R1 R2 address fields", f[27:18], {it.pa, it.ra});
        if (it.rd) begin
          chk(o[63:18] == '1 && o[17:0] == '0, "R5 release from turnaround", o, {46'h3FFF_FFFF_FFFF, 18'h0});
        end else begin
          chk(o == '1, "R4 write drives all bits", o, '1);
          chk(f[17:16] == 2'b10 && f[15:0] == it.d, "R4 R1 turnaround and data", f[17:0], {2'b10, it.d});
        end
      end
    end
  end

  initial begin
    int n0;
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 200000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(stat_rdata == 0 && mdc == 0 && mdio_oe == 0, "R9 reset state",
        {stat_rdata, 30'd0, mdc, mdio_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cmd(0, 1, 5'd3, 5'd0, 16'h3100, 1);
    wait_flag(0, "R4 write done set");
    chk(stat_rdata[1] == 0, "R4 no read flag after write", stat_rdata, 1);
    clear_status;
    chk(stat_rdata[1:0] == 0, "R6 flags cleared by status read", stat_rdata, 0);

    cmd(1, 0, 5'd1, 5'd2, 16'h0000, 1);
    wait_flag(1, "R5 read ready set");
    chk(stat_rdata[31:16] == phy_val(5'd1, 5'd2), "R5 read data", stat_rdata[31:16], phy_val(5'd1, 5'd2));
    clear_status;
    chk(stat_rdata[1:0] == 0 && stat_rdata[31:16] == phy_val(5'd1, 5'd2), "R6 clear keeps data",
        stat_rdata, {phy_val(5'd1, 5'd2), 16'h0});

    cmd(0, 1, 5'd31, 5'd31, 16'hFFFF, 1);
    wait_flag(0, "R4 all-ones write done");
    clear_status;
    cmd(0, 1, 5'd0, 5'd0, 16'h0000, 1);
    wait_flag(0, "R4 all-zeros write done");
    cmd(1, 0, 5'd31, 5'd17, 16'h0000, 1);
    wait_flag(1, "R5 read ready second read");
    chk(stat_rdata[31:16] == phy_val(5'd31, 5'd17), "R5 read data max address", stat_rdata[31:16], phy_val(5'd31, 5'd17));

    // both flags now set: new commands clear only their own flag
    cmd(0, 1, 5'd7, 5'd9, 16'hA55A, 1);
    chk(stat_rdata[1:0] == 2'b10, "R7 write clears only bit0", stat_rdata[1:0], 2'b10);
    wait_flag(0, "R7 write completes");
    cmd(1, 0, 5'd4, 5'd5, 16'h0000, 1);
    chk(stat_rdata[1:0] == 2'b01, "R7 read clears only bit1", stat_rdata[1:0], 2'b01);
    wait_flag(1, "R7 read completes");
    clear_status;

    // both bits set: read wins
    cmd(1, 1, 5'd12, 5'd3, 16'h1234, 1);
    wait_flag(1, "R1 both bits selects read");
    chk(stat_rdata[0] == 0, "R1 both bits no write flag", stat_rdata, 0);
    clear_status;

    // busy command ignored
    cmd(0, 1, 5'd2, 5'd6, 16'h0F0F, 1);
    repeat (20) @(negedge clk);
    cmd(1, 0, 5'd9, 5'd9, 16'h0000, 0);
    wait_flag(0, "R8 first write completes");
    n0 = frames;
    repeat (600) @(negedge clk);
    chk(frames == n0 && stat_rdata[1] == 0, "R8 busy command ignored", {frames, stat_rdata[1]}, {n0, 1'b0});
    clear_status;

    // neither command bit set
    cmd(0, 0, 5'd1, 5'd1, 16'hFFFF, 0);
    repeat (600) @(negedge clk);
    chk(frames == n0 && stat_rdata[1:0] == 0, "R8 empty command ignored", frames, n0);
    chk(mdc == 0 && mdio_oe == 0, "R3 idle mdc low and released", {mdc, mdio_oe}, 0);
    chk(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule